// File: doc/BRIEF.md
# Iterative Factorial Unit

This block computes the factorial of a small unsigned number by repeated multiplication. The number is held in a single down counter that can be loaded in parallel. A product register accumulates the running result. Its input comes through a two-way selector: one side is the constant one, the other is the output of a multiplier. The multiplier's two operands are the product register and the counter. A comparator checks whether the counter is greater than one, and that single bit decides whether the loop goes on.

A small state machine steps through the sequence:
- load the number and reset the product to one;
- test the count;
- multiply and decrement on the same edge;
- present the result.

The result port is driven only while `done` is high. At every other time the port is left at high impedance, so it can share a wire with other drivers.

A user pulses `start` for one cycle, holds `n_in` steady for the cycle after it, and waits for `done`. The result stays on the port until the next accepted start.

Top module: `fact_engine`

## Requirements
- R1: A `start` pulse seen while idle or done is accepted. The unit loads `n_in` into its counter in the clock cycle after the accepted start, so `n_in` must be valid in that cycle.
- R2: The load step sets the product register to 1. For n = 0 and n = 1 no multiplication happens, and the result is 1.
- R3: The result equals n! modulo 2^32. Each loop pass multiplies by the counter value before it is decremented.
- R4: Counting clock edges from the edge that accepts `start`, `done` rises after 2n+1 edges for n ≥ 2, and after 3 edges for n ≤ 1.
- R5: While `done` is high and `start` stays low, `done` stays high and `result` holds its value unchanged.
- R6: `result` is high-impedance whenever `done` is low.
- R7: A `start` pulse while a computation is in progress (load, test or multiply step) is ignored. The running computation finishes with its original n and its original latency.
- R8: A `start` pulse while `done` is high begins a new computation. `done` is low one edge later.
- R9: The synchronous active-high `rst` returns the unit to idle, with `done` low and `result` high-impedance, even in the middle of a computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a computation |
| n_in | input | 4 | Operand n, sampled in the cycle after an accepted start |
| done | output | 1 | High while the finished result is presented |
| result | output | 32 | n! modulo 2^32 while `done` is high, high-impedance otherwise |

## Verification
The bench drives n = 0 and n = 1 to catch a design that runs the loop body once too often, which would give 0 or a wrong latency. It drives n = 13 and n = 15 to confirm that wraparound modulo 2^32 is silent rather than saturating. Exact latency checks expose a multiply that uses the post-decrement count, because the result then comes out as (n-1)! or 0. A start pulse in mid-computation, carrying a different n, would restart or corrupt a design that does not ignore it. The bench also drives a pattern onto the shared result wire whenever `done` is low, so an output that drives the wire all the time shows up as a corrupted value.

// File: rtl/fact_pkg.sv
package fact_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_TEST = 3'd2,
    ST_MULT = 3'd3,
    ST_DONE = 3'd4
  } fact_state_e;
endpackage

// File: rtl/fact_cnt.sv
// Down counter with parallel load; sole storage of n, plus the n>1 comparator.
module fact_cnt #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          dec,
  input  logic [NW-1:0] din,
  output logic [NW-1:0] cnt,
  output logic          gt1
);
  localparam logic [NW-1:0] ONE = NW'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= din;
    else if (dec) cnt <= cnt - ONE;
  end

  assign gt1 = (cnt > ONE);
endmodule

// File: rtl/fact_prod.sv
// Product register fed by a two-way selector: constant one or multiplier output.
module fact_prod #(
  parameter int PW = 32,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          wr,
  input  logic [NW-1:0] cnt,
  output logic [PW-1:0] prod
);
  localparam int EXT = PW - NW;

  logic [PW-1:0] opb_w;
  logic [PW-1:0] mul_w;
  logic [PW-1:0] sel_w;

  assign opb_w = {{EXT{1'b0}}, cnt};
  assign mul_w = prod * opb_w;
  assign sel_w = init ? PW'(1) : mul_w;

  always_ff @(posedge clk) begin
    if (rst)              prod <= '0;
    else if (init || wr)  prod <= sel_w;
  end
endmodule

// File: rtl/fact_ctrl.sv
// Sequencer: idle -> load -> (test <-> mult) -> done.
module fact_ctrl
  import fact_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        gt1,
  output logic        ld,
  output logic        mul_en,
  output logic        done,
  output fact_state_e st
);
  fact_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: if (start) nxt = ST_LOAD;
      ST_LOAD: nxt = ST_TEST;
      ST_TEST: nxt = gt1 ? ST_MULT : ST_DONE;
      ST_MULT: nxt = ST_TEST;
      ST_DONE: if (start) nxt = ST_LOAD;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      done <= (nxt == ST_DONE);
    end
  end

  assign ld     = (st == ST_LOAD);
  assign mul_en = (st == ST_MULT);
endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
#(
  parameter int NW = 4,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] n_in,
  output logic          done,
  output logic [PW-1:0] result
);
  logic          ld_c;
  logic          mul_c;
  logic          gt1_c;
  logic [NW-1:0] cnt_q;
  logic [PW-1:0] prod_q;
  fact_state_e   st_q;

  fact_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .gt1    (gt1_c),
    .ld     (ld_c),
    .mul_en (mul_c),
    .done   (done),
    .st     (st_q)
  );

  fact_cnt #(.NW(NW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .ld  (ld_c),
    .dec (mul_c),
    .din (n_in),
    .cnt (cnt_q),
    .gt1 (gt1_c)
  );

  fact_prod #(.PW(PW), .NW(NW)) u_prod (
    .clk  (clk),
    .rst  (rst),
    .init (ld_c),
    .wr   (mul_c),
    .cnt  (cnt_q),
    .prod (prod_q)
  );

  // tri-state driver on the result pin
  assign result = done ? prod_q : {PW{1'bz}};
endmodule

// File: rtl/fact_engine_chk.sv
module fact_engine_chk
  import fact_pkg::*;
#(
  parameter int NW = 4,
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          ld_c,
  input logic          mul_c,
  input logic          gt1_c,
  input logic [NW-1:0] cnt_q,
  input logic [PW-1:0] prod_q,
  input fact_state_e   st_q
);
  logic busy;
  assign busy = (st_q == ST_LOAD) || (st_q == ST_TEST) || (st_q == ST_MULT);

  assert_loadone_R2: assert property (@(posedge clk) disable iff (rst)
    ld_c |=> prod_q == PW'(1));

  assert_cntdec_R3: assert property (@(posedge clk) disable iff (rst)
    mul_c |=> cnt_q == $past(cnt_q) - NW'(1));

  assert_mulgt1_R3: assert property (@(posedge clk) disable iff (rst)
    mul_c |-> gt1_c);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && prod_q == $past(prod_q)));

  assert_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !ld_c);

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);
endmodule

bind fact_engine fact_engine_chk #(.NW(NW), .PW(PW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .ld_c   (ld_c),
  .mul_c  (mul_c),
  .gt1_c  (gt1_c),
  .cnt_q  (cnt_q),
  .prod_q (prod_q),
  .st_q   (st_q)
);

// File: tb/fact_engine_tb_top.sv
module fact_engine_tb_top;
  localparam int NV = 10;
  localparam logic [31:0] PAT = 32'h5A5A_0000;
  localparam logic [3:0]  VN [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd7, 4'd10, 4'd12, 4'd13, 4'd4};
  localparam logic [31:0] VE [NV] = '{32'd1, 32'd1, 32'd2, 32'd6, 32'd120, 32'd5040,
                                      32'd3628800, 32'd479001600, 32'd1932053504, 32'd24};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  n_in = '0;
  logic        done;
  wire  [31:0] res_w;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          ended = 1'b0;

  always #10 clk = ~clk;

  // bench drives a pattern onto the shared wire whenever the unit must not
  assign res_w = done ? 32'bz : PAT;

  fact_engine dut_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .n_in   (n_in),
    .done   (done),
    .result (res_w)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fact(input int n);
    logic [31:0] p = 32'd1;
    for (int i = 2; i <= n; i++) p = p * 32'(i);
    return p;
  endfunction

  function automatic int ref_lat(input int n);
    return (n <= 1) ? 3 : 2 * n + 1;
  endfunction

  task automatic run(input logic [3:0] n, output int lat);
    @(negedge clk); n_in = n; start = 1'b1; lat = 0;
    @(negedge clk); start = 1'b0; lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R6 reset result hi-z", res_w, PAT);

    // table walk: R1 R2 R3 R4
    for (int k = 0; k < NV; k++) begin
      run(VN[k], lat);
      chk($sformatf("R3 result n=%0d", VN[k]), res_w, VE[k]);
      chk($sformatf("R4 latency n=%0d", VN[k]), 32'(lat), 32'(ref_lat(int'(VN[k]))));
    end

    // wraparound at 15
    run(4'd15, lat);
    chk("R3 wrap n=15", res_w, ref_fact(15));
    chk("R2 n=1 gives 1 idle-to-done", 32'd1, ref_fact(1));

    // R5: hold in DONE
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R5 done held", {31'd0, done}, 32'd1);
      chk("R5 result stable", res_w, ref_fact(15));
    end

    // R8: restart from DONE, then R6 hi-z while busy
    @(negedge clk); n_in = 4'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 done drops", {31'd0, done}, 32'd0);
    chk("R6 busy result hi-z", res_w, PAT);
    // R7: start with a different n mid-run is ignored
    @(negedge clk); @(negedge clk);
    n_in = 4'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 4;
    while (!done && lat < 200) begin
      @(negedge clk); lat++;
    end
    chk("R7 busy start ignored result", res_w, 32'd720);
    chk("R7 busy start ignored latency", 32'(lat), 32'd13);

    // R1: n_in sampled in the cycle after start
    @(negedge clk); n_in = 4'd9; start = 1'b1;
    @(negedge clk); start = 1'b0; n_in = 4'd4;
    @(negedge clk); n_in = 4'd11;
    while (!done) @(negedge clk);
    chk("R1 n sampled after start", res_w, 32'd24);

    // R9: reset in mid computation
    @(negedge clk); n_in = 4'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 mid-run reset done", {31'd0, done}, 32'd0);
    chk("R9 mid-run reset hi-z", res_w, PAT);
    repeat (30) @(negedge clk);
    chk("R9 stays idle", {31'd0, done}, 32'd0);
    run(4'd0, lat);
    chk("R2 n=0 after reset", res_w, 32'd1);

    finish_up();
  end
endmodule